// File: doc/BRIEF.md
# UART Receive Timeout Detector

This block watches a UART receive FIFO and raises a timeout flag when characters sit in the FIFO while neither the host nor the serial line has touched it for four full character times. Host software uses the flag, through the interrupt prioritizer, to collect a short tail of data that never reached the FIFO trigger level.

The flag is produced only while FIFO operation is enabled and the FIFO holds at least one character. The measured interval is counted in 16x baud ticks, and its length is scaled by the configured character length in bits. That length counts the start, data, parity and stop bits. Timing starts at the centre of the first stop bit of the last character received, which is when the receiver pulses its push strobe. Either a host read of the receive holding register or a new push restarts the count. Only a host read clears the flag.

Top module: `uart_rx_timeout`

## Requirements
- R1: After reset `rto_flag` is 0.
- R2: With `fifo_en` and `rx_nonempty` both 1, `rto_flag` becomes 1 one clock after the Nth qualifying `baud_tick` following the last restart, and stays 0 before that. A qualifying tick is one with no read or push in the same cycle. N = CHAR_TIMES × OVERSAMPLE × `char_bits`, and the defaults give N = 64 × `char_bits`. This applies to both the multiplier and the shifter form of the limit.
- R3: A `rx_push` pulse restarts the tick count from zero and leaves `rto_flag` unchanged.
- R4: A `rhr_read` pulse clears `rto_flag` on the next clock and restarts the tick count. A read takes priority over a terminal tick in the same cycle.
- R5: If `fifo_en` is 0 or `rx_nonempty` is 0 in a cycle, `rto_flag` is 0 on the next clock and the tick count returns to zero.
- R6: Once set, `rto_flag` stays 1 through any number of further ticks and pushes until a read or R5 clears it.
- R7: Clock cycles with `baud_tick` at 0 do not advance the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| rx_nonempty | input | 1 | Receive FIFO holds at least one character |
| rhr_read | input | 1 | Host read strobe of the receive holding register |
| rx_push | input | 1 | Character pushed into the FIFO, at the centre of its first stop bit |
| baud_tick | input | 1 | Oversampling tick (OVERSAMPLE per bit) |
| char_bits | input | CHAR_LEN_W | Character length in bits, including start, parity and stop bits |
| rto_flag | output | 1 | Receive timeout indication |

## Verification
The bench builds two instances. The first uses the defaults (16 ticks per bit, four character times, 4-bit length), so the power-of-two shifter form of the limit is exercised and windows of up to 960 ticks are possible. The second uses 3 ticks per bit and two character times, which selects the multiplier form and gives windows of only 6 ticks per bit. With those short windows, random traffic reaches a timeout, a set flag, and a clear of that flag many times. Directed runs at the default scale reach the exact terminal tick and a read that lands on that tick.

// File: rtl/uart_rto_pkg.sv
package uart_rto_pkg;

   // Largest terminal count the limit logic can produce
   function automatic int rto_max_limit(input int len_w, input int scale);
      return scale * ((1 << len_w) - 1);
   endfunction

   function automatic bit rto_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rto_limit.sv
module rto_limit #(
   parameter int CHAR_LEN_W = 4,
   parameter int SCALE      = 64,
   parameter int CNT_W      = 10
) (
   input  logic [CHAR_LEN_W-1:0] char_bits,
   output logic [CNT_W-1:0]      limit
);
   import uart_rto_pkg::*;

   generate
      if (rto_is_pow2(SCALE)) begin : g_shift
         localparam int SHIFT = $clog2(SCALE);
         always_comb limit = CNT_W'(char_bits) << SHIFT;
      end else begin : g_mult
         always_comb limit = CNT_W'(char_bits) * CNT_W'(SCALE);
      end
   endgenerate

endmodule

// File: rtl/rto_counter.sv
module rto_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             restart,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   logic [CNT_W-1:0] cnt;
   logic             armed;
   logic [CNT_W:0]   cnt_inc;

   always_comb begin
      cnt_inc = {1'b0, cnt} + 1'b1;
      expire  = active && !restart && armed && tick && (cnt_inc >= {1'b0, limit});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b1;
      end else if (!active || restart) begin
         cnt   <= '0;
         armed <= 1'b1;
      end else if (armed && tick) begin
         if (expire) begin
            cnt   <= '0;
            armed <= 1'b0;
         end else begin
            cnt <= cnt_inc[CNT_W-1:0];
         end
      end
   end

   // R5
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt == '0) && armed);

   // R3
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && restart) |=> (cnt == '0) && armed && !expire);

   // R7
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !restart && !tick) |=> $stable(cnt));

endmodule

// File: rtl/rto_flag.sv
module rto_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic read,
   input  logic expire,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (!active) flag <= 1'b0;
      else if (read)   flag <= 1'b0;
      else if (expire) flag <= 1'b1;
   end

   // R4
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      read |=> !flag);

   // R6
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && active && !read) |=> flag);

   // R2
   rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(expire));

endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
   parameter int CHAR_LEN_W = 4,
   parameter int OVERSAMPLE = 16,
   parameter int CHAR_TIMES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fifo_en,
   input  logic                  rx_nonempty,
   input  logic                  rhr_read,
   input  logic                  rx_push,
   input  logic                  baud_tick,
   input  logic [CHAR_LEN_W-1:0] char_bits,
   output logic                  rto_flag
);
   import uart_rto_pkg::*;

   localparam int SCALE   = OVERSAMPLE * CHAR_TIMES;
   localparam int MAX_LIM = rto_max_limit(CHAR_LEN_W, SCALE);
   localparam int CNT_W   = $clog2(MAX_LIM + 1);

   generate
      if (CHAR_LEN_W < 1 || CHAR_LEN_W > 8) begin : g_bad_len
         $error("CHAR_LEN_W must lie in 1..8");
      end
      if (OVERSAMPLE < 1 || CHAR_TIMES < 1) begin : g_bad_scale
         $error("OVERSAMPLE and CHAR_TIMES must be at least 1");
      end
   endgenerate

   logic             active;
   logic             restart;
   logic             expire;
   logic [CNT_W-1:0] limit;

   always_comb begin
      active  = fifo_en && rx_nonempty;
      restart = rhr_read || rx_push;
   end

   rto_limit #(
      .CHAR_LEN_W(CHAR_LEN_W),
      .SCALE     (SCALE),
      .CNT_W     (CNT_W)
   ) u_limit (
      .char_bits(char_bits),
      .limit    (limit)
   );

   rto_counter #(
      .CNT_W(CNT_W)
   ) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .restart(restart),
      .tick   (baud_tick),
      .limit  (limit),
      .expire (expire)
   );

   rto_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .active(active),
      .read  (rhr_read),
      .expire(expire),
      .flag  (rto_flag)
   );

   // R5
   inactive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_en && rx_nonempty) |=> !rto_flag);

   // R3
   push_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rto_flag && fifo_en && rx_nonempty && rx_push && !rhr_read) |=> rto_flag);

endmodule

// File: tb/tb_uart_rx_timeout.sv
module tb_uart_rx_timeout;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, ne = 1'b0, rd = 1'b0, ps = 1'b0, tk = 1'b0;
   logic [3:0] bits = 4'd10;
   logic       flag_a, flag_b;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // model state: A = defaults (scale 64), B = scale 6
   int c_a = 0, c_b = 0;
   bit a_a = 1, a_b = 1, f_a = 0, f_b = 0;

   always #2 clk = ~clk;

   uart_rx_timeout dut (
      .clk(clk), .rst_n(rst_n), .fifo_en(en), .rx_nonempty(ne),
      .rhr_read(rd), .rx_push(ps), .baud_tick(tk), .char_bits(bits),
      .rto_flag(flag_a));

   uart_rx_timeout #(.CHAR_LEN_W(4), .OVERSAMPLE(3), .CHAR_TIMES(2)) dut_b (
      .clk(clk), .rst_n(rst_n), .fifo_en(en), .rx_nonempty(ne),
      .rhr_read(rd), .rx_push(ps), .baud_tick(tk), .char_bits(bits),
      .rto_flag(flag_b));

   function automatic int term_of(input int scale, input int b);
      return scale * b;
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic model_one(inout int c, inout bit a, inout bit f, input int term);
      if (!(en && ne)) begin
         c = 0; a = 1; f = 0;
      end else if (rd || ps) begin
         c = 0; a = 1;
         if (rd) f = 0;
      end else if (a && tk) begin
         if (c + 1 >= term) begin
            f = 1; a = 0; c = 0;
         end else c++;
      end
   endtask

   task automatic cyc(input bit e, input bit n, input bit r, input bit p, input bit t);
      string tag;
      en = e; ne = n; rd = r; ps = p; tk = t;
      tag = !(e && n) ? "R5" : r ? "R4" : p ? "R3" : t ? "R2" : "R7";
      @(posedge clk);
      model_one(c_a, a_a, f_a, term_of(64, int'(bits)));
      model_one(c_b, a_b, f_b, term_of(6, int'(bits)));
      #1;
      check({tag, " inst A"}, flag_a, f_a);
      check({tag, " inst B"}, flag_b, f_b);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h5eed_0954;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset A", flag_a, 1'b0);
      check("R1 reset B", flag_b, 1'b0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R2: exact boundary, bits=10, default limit 640 ticks
      bits = 4'd10;
      cyc(1, 1, 0, 1, 0);
      for (int i = 1; i <= 640; i++) begin
         cyc(1, 1, 0, 0, 1);
         check("R2 boundary", flag_a, (i >= 640));
      end

      // R6: ticks and pushes keep flag set
      for (int i = 0; i < 100; i++) cyc(1, 1, 0, 0, 1);
      check("R6 hold", flag_a, 1'b1);
      cyc(1, 1, 0, 1, 1);
      check("R3 push keeps flag", flag_a, 1'b1);
      cyc(1, 1, 1, 0, 1);
      check("R4 read clears", flag_a, 1'b0);

      // R4: read on the terminal tick wins, count restarts
      bits = 4'd1;
      cyc(1, 1, 0, 1, 0);
      for (int i = 0; i < 63; i++) cyc(1, 1, 0, 0, 1);
      cyc(1, 1, 1, 0, 1);
      check("R4 read beats terminal", flag_a, 1'b0);
      for (int i = 0; i < 63; i++) cyc(1, 1, 0, 0, 1);
      check("R4 restarted count", flag_a, 1'b0);
      cyc(1, 1, 0, 0, 1);
      check("R4 full window after read", flag_a, 1'b1);

      // R5: disabling FIFO mode or emptying clears
      cyc(0, 1, 0, 0, 1);
      check("R5 fifo off", flag_a, 1'b0);
      for (int i = 0; i < 64; i++) cyc(1, 1, 0, 0, 1);
      check("R5 counted from enable", flag_a, 1'b1);
      cyc(1, 0, 0, 0, 0);
      check("R5 fifo empty", flag_a, 1'b0);

      // R7: sparse ticks, bits=1 -> 64 ticks
      cyc(1, 1, 0, 1, 0);
      begin
         int ticks;
         ticks = 0;
         for (int i = 0; i < 200; i++) begin
            bit t;
            t = (i % 3) == 2;
            cyc(1, 1, 0, 0, t);
            if (t) ticks++;
            check("R7 sparse ticks", flag_a, (ticks >= 64));
         end
      end

      // random phase
      for (int i = 0; i < 30000; i++) begin
         if ((i % 500) == 0) bits = 4'($urandom_range(1, 3));
         cyc(($urandom_range(0, 99) < 98), ($urandom_range(0, 99) < 96),
             ($urandom_range(0, 199) == 0), ($urandom_range(0, 149) == 0),
             ($urandom_range(0, 1) == 1));
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule